// File: doc/BRIEF.md
# Hold-and-Modify Pixel Color Decoder

This block turns a stream of compact pixel codes into 24-bit RGB colors. Each code carries two control bits and a data field. The control bits either fetch a full color from a 64-entry palette or take the color of the previous pixel and overwrite exactly one of its three components with the data field. The decoder therefore holds the most recent color as running state, and every output depends on the pixels that came before it on the same line.

Two code formats are supported and selected per pixel by `mode_wide`. The narrow format is 6 bits long with a 4-bit data field. In this format a modified component is stored as the nibble repeated twice, and only palette entries 0 to 15 can be reached. The wide format is 8 bits long with a 6-bit data field. In this format the field can address all 64 palette entries, or it replaces the upper six bits of one component while that component's two low bits are kept.

A line-start marker sets the held color back to palette entry 0, so every scan line starts from a known color. The palette is loaded through a synchronous write port. Each decoded color appears one clock after its code, together with a valid flag.

Top module: `ham_pixel_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` becomes 0 and `out_rgb` becomes 0 (red in bits 23:16, green in 15:8, blue in 7:0).
- R2: `out_valid` equals the `pix_valid` of the previous clock edge, and `out_rgb` then holds the color decoded from the `pix_code` of that edge.
- R3: Control value 00 loads the palette entry addressed by the data field as the new color. In narrow mode the control bits are `pix_code[5:4]` and the index is `pix_code[3:0]`, so only entries 0 to 15 are reachable. In wide mode the control bits are `pix_code[7:6]` and the index is `pix_code[5:0]`.
- R4: Control value 01 replaces red and keeps green and blue from the held color.
- R5: Control value 10 replaces green and keeps red and blue. Control value 11 replaces blue and keeps red and green.
- R6: In narrow mode a modify sets the chosen component to the 4-bit data repeated in both nibbles. `pix_code[7:6]` has no effect in this mode.
- R7: In wide mode a modify writes the 6-bit data into bits 7:2 of the chosen component and keeps bits 1:0 from the held color.
- R8: When `line_start` is high, palette entry 0 becomes the base color before any pixel in the same cycle is decoded. If no valid pixel comes with the marker, palette entry 0 becomes the held color.
- R9: A cycle with `pix_valid` low and `line_start` low leaves the held color unchanged.
- R10: A palette write with `pal_we` high takes effect at that clock edge. Pixels decoded in later cycles see the new entry.
- R11: The mode is sampled for each pixel, so the format can change from one line to the next without any other action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | 0 selects the 6-bit code format, 1 selects the 8-bit format |
| line_start | input | 1 | Resets the held color to palette entry 0 in this cycle |
| pix_valid | input | 1 | `pix_code` holds a pixel in this cycle |
| pix_code | input | 8 | Pixel code (control bits and data field) |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 6 | Palette write address |
| pal_wdata | input | 24 | Palette write data, laid out as RGB 8:8:8 |
| out_valid | output | 1 | `out_rgb` holds a decoded pixel |
| out_rgb | output | 24 | Decoded color, laid out as RGB 8:8:8 |

## Verification
The held color is state that the next modify code reads. If that state is wrong, the error shows at the ports on the very next valid pixel, in the two components that pixel keeps. It then persists until a palette load or a line start clears it. Because of this, the random runs mix long modify chains with palette reloads in mid-line and with idle gaps. Each output is compared against a reference model one cycle after its code. A wrong low-bit carry in wide mode or a failed reset at a line boundary is therefore reported within a cycle of the pixel that exposes it.

// File: rtl/hamdec_pkg.sv
package hamdec_pkg;

    localparam int COMP_W    = 8;
    localparam int RGB_W     = 3 * COMP_W;
    localparam int PAL_DEPTH = 64;
    localparam int PAL_AW    = $clog2(PAL_DEPTH);
    localparam int CODE_W    = 8;
    localparam int NARROW_DW = 4;
    localparam int WIDE_DW   = 6;
    localparam int KEEP_W    = COMP_W - WIDE_DW;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        CTL_PALETTE = 2'b00,
        CTL_RED     = 2'b01,
        CTL_GREEN   = 2'b10,
        CTL_BLUE    = 2'b11
    } ctl_e;

    typedef struct packed {
        ctl_e               ctl;
        logic [WIDE_DW-1:0] data;
    } code_t;

    // Separate a raw code into its control and data fields for the selected format.
    function automatic code_t split_code(input logic [CODE_W-1:0] raw, input logic wide);
        code_t c;
        if (wide) begin
            c.ctl  = ctl_e'(raw[WIDE_DW+1:WIDE_DW]);
            c.data = raw[WIDE_DW-1:0];
        end else begin
            c.ctl  = ctl_e'(raw[NARROW_DW+1:NARROW_DW]);
            c.data = {{(WIDE_DW-NARROW_DW){1'b0}}, raw[NARROW_DW-1:0]};
        end
        return c;
    endfunction

    // Build a new component value from the data field and the held component.
    function automatic logic [COMP_W-1:0] new_comp(input logic [WIDE_DW-1:0] d,
                                                   input logic wide,
                                                   input logic [COMP_W-1:0] held);
        if (wide)
            return {d, held[KEEP_W-1:0]};
        else
            return {d[NARROW_DW-1:0], d[NARROW_DW-1:0]};
    endfunction

endpackage

// File: rtl/ham_palette.sv
module ham_palette
    import hamdec_pkg::*;
#(
    parameter int DEPTH = PAL_DEPTH,
    parameter int WIDTH = RGB_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] entry0
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata  = mem[raddr];
    assign entry0 = mem[0];

endmodule

// File: rtl/ham_color_step.sv
module ham_color_step
    import hamdec_pkg::*;
(
    input  logic  wide,
    input  code_t code,
    input  rgb_t  base,
    input  rgb_t  pal_color,
    output rgb_t  next_color
);

    always_comb begin
        next_color = base;
        unique case (code.ctl)
            CTL_PALETTE: next_color   = pal_color;
            CTL_RED:     next_color.r = new_comp(code.data, wide, base.r);
            CTL_GREEN:   next_color.g = new_comp(code.data, wide, base.g);
            CTL_BLUE:    next_color.b = new_comp(code.data, wide, base.b);
        endcase
    end

endmodule

// File: rtl/ham_pixel_decoder.sv
module ham_pixel_decoder
    import hamdec_pkg::*;
#(
    parameter int DEPTH = PAL_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wide,
    input  logic              line_start,
    input  logic              pix_valid,
    input  logic [CODE_W-1:0] pix_code,
    input  logic              pal_we,
    input  logic [AW-1:0]     pal_addr,
    input  logic [RGB_W-1:0]  pal_wdata,
    output logic              out_valid,
    output logic [RGB_W-1:0]  out_rgb
);

    code_t cd;
    rgb_t  pal_rd, pal0, base, next_color, held_q;
    logic  valid_q;

    assign cd = split_code(pix_code, mode_wide);

    ham_palette #(.DEPTH(DEPTH), .WIDTH(RGB_W)) u_palette (
        .clk    (clk),
        .rst    (rst),
        .we     (pal_we),
        .waddr  (pal_addr),
        .wdata  (pal_wdata),
        .raddr  (cd.data[AW-1:0]),
        .rdata  (pal_rd),
        .entry0 (pal0)
    );

    assign base = line_start ? pal0 : held_q;

    ham_color_step u_step (
        .wide       (mode_wide),
        .code       (cd),
        .base       (base),
        .pal_color  (pal_rd),
        .next_color (next_color)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= pix_valid;
            if (pix_valid)       held_q <= next_color;
            else if (line_start) held_q <= pal0;
        end
    end

    assign out_valid = valid_q;
    assign out_rgb   = held_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> out_valid);                                       // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !out_valid);                                     // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pix_valid && !line_start) |=> $stable(held_q));               // R9
    AST_RED_KEEPS_GB: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !line_start && cd.ctl == CTL_RED)
        |=> (held_q.g == $past(held_q.g) && held_q.b == $past(held_q.b))); // R4
    AST_BLUE_KEEPS_RG: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !line_start && cd.ctl == CTL_BLUE)
        |=> (held_q.r == $past(held_q.r) && held_q.g == $past(held_q.g))); // R5
    AST_WIDE_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !line_start && mode_wide && cd.ctl == CTL_GREEN)
        |=> (held_q.g[KEEP_W-1:0] == $past(held_q.g[KEEP_W-1:0])));     // R7
    AST_LINE_BASE: assert property (@(posedge clk) disable iff (rst)
        (line_start && !pix_valid) |=> (held_q == $past(pal0)));        // R8

endmodule

// File: tb/ham_pixel_decoder_tb.sv
module ham_pixel_decoder_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_wide, line_start, pix_valid, pal_we;
    logic [7:0]  pix_code;
    logic [5:0]  pal_addr;
    logic [23:0] pal_wdata;
    logic        out_valid;
    logic [23:0] out_rgb;

    always #5 clk = ~clk;

    ham_pixel_decoder u_dut (
        .clk(clk), .rst(rst), .mode_wide(mode_wide), .line_start(line_start),
        .pix_valid(pix_valid), .pix_code(pix_code), .pal_we(pal_we),
        .pal_addr(pal_addr), .pal_wdata(pal_wdata),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    logic [23:0] mpal [64];
    logic [23:0] mheld;
    int n_run = 0;
    int n_fail = 0;

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model_step(input logic [23:0] base,
                                               input logic [7:0] code, input logic wide);
        logic [1:0]  ctl;
        logic [5:0]  d;
        logic [7:0]  comp, old;
        logic [23:0] res;
        ctl = wide ? code[7:6] : code[5:4];
        d   = wide ? code[5:0] : {2'b00, code[3:0]};
        if (ctl == 2'b00) return mpal[d];
        old  = (ctl == 2'b01) ? base[23:16] : (ctl == 2'b10) ? base[15:8] : base[7:0];
        comp = wide ? {d, old[1:0]} : {d[3:0], d[3:0]};
        res  = base;
        case (ctl)
            2'b01:   res[23:16] = comp;
            2'b10:   res[15:8]  = comp;
            default: res[7:0]   = comp;
        endcase
        return res;
    endfunction

    task automatic pixel(input bit ls, input bit v, input logic [7:0] code,
                         input logic wide, input string req);
        logic [23:0] base;
        @(negedge clk);
        line_start = ls; pix_valid = v; pix_code = code; mode_wide = wide;
        base = ls ? mpal[0] : mheld;
        if (v)       mheld = model_step(base, code, wide);
        else if (ls) mheld = mpal[0];
        @(posedge clk); #1;
        check({req, " valid"}, {23'd0, out_valid}, {23'd0, v});
        if (v || ls) check(req, out_rgb, mheld);
        pix_valid = 1'b0; line_start = 1'b0;
    endtask

    task automatic pal_write(input logic [5:0] a, input logic [23:0] d);
        @(negedge clk);
        pal_we = 1'b1; pal_addr = a; pal_wdata = d;
        @(posedge clk); #1;
        pal_we = 1'b0;
        mpal[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic wide;
        void'($urandom(32'd4242));
        rst = 1'b1; mode_wide = 0; line_start = 0; pix_valid = 0; pal_we = 0;
        pix_code = '0; pal_addr = '0; pal_wdata = '0;
        for (int i = 0; i < 64; i++) mpal[i] = '0;
        mheld = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {23'd0, out_valid}, 24'd0);
        check("R1 reset rgb", out_rgb, 24'd0);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < 64; i++) pal_write(i[5:0], $urandom());

        // narrow line: line start, palette load, modify run
        pixel(1, 1, 8'h03, 0, "R8 R3 narrow line start load");
        pixel(0, 1, 8'h1A, 0, "R4 R6 narrow red");
        pixel(0, 1, 8'h25, 0, "R5 narrow green");
        pixel(0, 1, 8'h3F, 0, "R5 narrow blue");
        pixel(0, 1, 8'hD7, 0, "R6 upper bits ignored");
        pixel(0, 0, 8'h01, 0, "R9 idle gap");
        pixel(0, 1, 8'h10, 0, "R9 modify after gap");
        pixel(0, 1, 8'h0F, 0, "R3 narrow top index");
        pixel(1, 0, 8'h00, 0, "R8 marker alone");
        pixel(0, 1, 8'h2C, 0, "R8 modify after marker");

        // palette write visible next cycle
        pal_write(6'd5, 24'hA1B2C3);
        pixel(0, 1, 8'h05, 0, "R10 new entry seen");

        // wide line after mode change
        pixel(1, 1, 8'h2D, 1, "R11 R3 wide index 45");
        pixel(0, 1, 8'h6A, 1, "R7 wide red keeps low bits");
        pixel(0, 1, 8'hAA, 1, "R7 wide green");
        pixel(0, 1, 8'hFF, 1, "R7 wide blue");
        pixel(0, 1, 8'h3F, 1, "R3 wide index 63");
        pixel(1, 1, 8'h41, 0, "R11 back to narrow");

        // random lines
        wide = 0;
        for (int i = 0; i < 4000; i++) begin
            bit ls, v;
            ls = ($urandom_range(0, 31) == 0);
            v  = ($urandom_range(0, 3) != 0);
            if (ls) wide = $urandom_range(0, 1);
            if ($urandom_range(0, 63) == 0)
                pal_write($urandom_range(0, 63), $urandom());
            else
                pixel(ls, v, $urandom_range(0, 255), wide, "R2 random stream");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule